// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

The engine paints an axis-aligned rectangle with one solid colour. Software programs a fill colour, a plane mask, a per-pixel mask and a clip window. It then gives the rectangle as two absolute corners through a single pair of corner registers: a Y write followed by an X write latches one corner, and a second Y/X pair latches the opposite corner. The X write of the second pair hands the rectangle to the engine. The engine clips the rectangle to the window and walks it row by row. It emits one pixel write per accepted valid/ready handshake on its pixel port, carrying the coordinates, the fill colour and the plane mask.

A rectangle that arrives while a fill is still running waits in a single hold slot and starts once the running fill ends. While that slot is occupied, the draw-status word reports that the engine cannot take more work. Software polls an engine-status word to see whether drawing is still in progress.

All registers are word addresses on a 4-bit address bus. The write registers are: 0 fill colour, 1 plane mask, 2 pixel mask, 4 clip minimum X, 5 clip minimum Y, 6 clip maximum X, 7 clip maximum Y, 8 corner Y and 9 corner X. The read words are 12 for engine status and 13 for draw status. Any other read address returns 0.

Top module: `rect_fill`

## Requirements
- R1: After reset, pixValid is 0, the engine-status word (read address 12) reads 0 and the draw-status word (read address 13) reads 0.
- R2: A write to address 8 (corner Y) followed by a write to address 9 (corner X) latches the first corner. A second address 8 / address 9 pair latches the opposite corner and launches the fill. From the clock edge that takes the second X write, bit 28 of the engine-status word is 1, and it stays 1 until the last pixel of the fill has been accepted.
- R3: The fill covers columns x0 <= x < x1 and rows y0 <= y < y1. It walks row by row with X ascending inside each row, and issues exactly one pixel per cycle in which pixValid and pixReady are both 1. While pixReady is 0, pixValid stays 1 and pixX and pixY stay unchanged.
- R4: A rectangle with x1 <= x0 or y1 <= y0 issues no pixel, and bit 28 of the engine-status word returns to 0.
- R5: Only pixels with clip minimum X (address 4) <= x <= clip maximum X (address 6) and clip minimum Y (address 5) <= y <= clip maximum Y (address 7) are issued. After reset the minima are 0 and the maxima are all ones.
- R6: Every pixel carries pixColor equal to the fill colour register (address 0) and pixPlanes equal to the plane mask register (address 1). After reset the plane mask is all ones.
- R7: A pixel whose column x has bit (x mod 32) of the pixel mask register (address 2) equal to 0 is skipped and never issued. After reset the pixel mask is all ones.
- R8: A rectangle completed while a fill is running is held and starts after the running fill ends, so its pixels follow those of the running fill. While it is held, bits 31 and 29 of the draw-status word are both 1, giving the value 0xA0000000.
- R9: Corner writes (addresses 8 and 9) made while a rectangle is held are ignored: the held rectangle is kept and no other rectangle is drawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write word address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 4 | Status read word address |
| rdData | output | 32 | Status read data, combinational |
| pixValid | output | 1 | A pixel write is offered |
| pixReady | input | 1 | Sink accepts the offered pixel |
| pixX | output | 12 | Pixel column |
| pixY | output | 12 | Pixel row |
| pixColor | output | 32 | Pixel colour |
| pixPlanes | output | 32 | Plane write mask for the pixel |

## Verification
The hardest state to reach from the ports is a second rectangle waiting in the hold slot while a third one is written on top of it. To get there, the pixel sink holds pixReady low so that the first fill cannot finish. The bench waits until that fill owns the walker, then writes a second and a third rectangle. It then checks the draw-status word, releases the sink, and compares the full pixel stream against the first rectangle followed only by the second. Stalls are produced by a pseudo-random ready pattern. During every stall the bench checks that the offered pixel holds still.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_COLOR   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PLANES  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PIXMASK = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLIP_LO = 4'd4;  // +0 X, +1 Y
  localparam logic [ADDR_W-1:0] A_CLIP_HI = 4'd6;  // +0 X, +1 Y
  localparam logic [ADDR_W-1:0] A_RECT_Y  = 4'd8;
  localparam logic [ADDR_W-1:0] A_RECT_X  = 4'd9;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd12;
  localparam logic [ADDR_W-1:0] A_DRAW    = 4'd13;

  localparam int BUSY_BIT     = 28;
  localparam int NOTREADY_BIT = 29;
  localparam int SIGN_BIT     = 31;

  typedef struct packed {
    logic take;  // load the walker from the hold slot, free the slot
    logic step;  // move the walker to the next pixel
  } ctrl_t;

  typedef enum logic {S_IDLE, S_RUN} state_t;
endpackage

// File: rtl/fill_datapath.sv
module fill_datapath
  import fill_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  ctrl_t             ctrl,
  input  logic              pixValid,
  output logic              pendValid,
  output logic              jobEmpty,
  output logic              lastPix,
  output logic              curMaskOn,
  output logic [CW-1:0]     posX,
  output logic [CW-1:0]     posY,
  output logic [DW-1:0]     fgColor,
  output logic [DW-1:0]     planeMask
);
  localparam int MW = $clog2(DW);
  localparam int NAXIS = 2;  // 0 = X, 1 = Y

  logic [DW-1:0] pixMask;
  logic [CW-1:0] clipMin [NAXIS];
  logic [CW-1:0] clipMax [NAXIS];

  // corner latch
  logic          vtxSel;
  logic [CW-1:0] firstX, firstY, secondY;
  logic [CW-1:0] pendLo [NAXIS];
  logic [CW-1:0] pendHi [NAXIS];

  // clipped span per axis
  logic [CW-1:0] spanLo [NAXIS];
  logic [CW:0]   spanHi [NAXIS];
  logic [NAXIS-1:0] axisEmpty;

  // walker
  logic [CW-1:0] startX;
  logic [CW:0]   endX, endY;
  logic          rowEnd;

  logic rectWr;
  assign rectWr = wrEn && !pendValid;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fgColor   <= '0;
      planeMask <= '1;
      pixMask   <= '1;
      for (int a = 0; a < NAXIS; a++) begin
        clipMin[a] <= '0;
        clipMax[a] <= '1;
      end
    end else if (wrEn) begin
      if (wrAddr == A_COLOR)   fgColor   <= wrData;
      if (wrAddr == A_PLANES)  planeMask <= wrData;
      if (wrAddr == A_PIXMASK) pixMask   <= wrData;
      for (int a = 0; a < NAXIS; a++) begin
        if (wrAddr == A_CLIP_LO + ADDR_W'(a)) clipMin[a] <= wrData[CW-1:0];
        if (wrAddr == A_CLIP_HI + ADDR_W'(a)) clipMax[a] <= wrData[CW-1:0];
      end
    end
  end

  // corner latching and the hold slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vtxSel    <= 1'b0;
      firstX    <= '0;
      firstY    <= '0;
      secondY   <= '0;
      pendValid <= 1'b0;
      for (int a = 0; a < NAXIS; a++) begin
        pendLo[a] <= '0;
        pendHi[a] <= '0;
      end
    end else begin
      if (ctrl.take) pendValid <= 1'b0;
      if (rectWr && wrAddr == A_RECT_Y) begin
        if (vtxSel) secondY <= wrData[CW-1:0];
        else        firstY  <= wrData[CW-1:0];
      end
      if (rectWr && wrAddr == A_RECT_X) begin
        if (vtxSel) begin
          pendLo[0] <= firstX;
          pendLo[1] <= firstY;
          pendHi[0] <= wrData[CW-1:0];
          pendHi[1] <= secondY;
          pendValid <= 1'b1;
          vtxSel    <= 1'b0;
        end else begin
          firstX <= wrData[CW-1:0];
          vtxSel <= 1'b1;
        end
      end
    end
  end

  // clip the held rectangle on each axis
  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    logic [CW:0] hiLimit;
    logic [CW:0] hiWide;
    assign hiLimit   = {1'b0, clipMax[a]} + (CW+1)'(1);
    assign hiWide    = {1'b0, pendHi[a]};
    assign spanLo[a] = (pendLo[a] > clipMin[a]) ? pendLo[a] : clipMin[a];
    assign spanHi[a] = (hiWide < hiLimit) ? hiWide : hiLimit;
    assign axisEmpty[a] = ({1'b0, spanLo[a]} >= spanHi[a]);
  end

  assign jobEmpty = |axisEmpty;

  // raster walker
  assign rowEnd  = (({1'b0, posX} + (CW+1)'(1)) == endX);
  assign lastPix = rowEnd && (({1'b0, posY} + (CW+1)'(1)) == endY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posX   <= '0;
      posY   <= '0;
      startX <= '0;
      endX   <= '0;
      endY   <= '0;
    end else if (ctrl.take) begin
      posX   <= spanLo[0];
      posY   <= spanLo[1];
      startX <= spanLo[0];
      endX   <= spanHi[0];
      endY   <= spanHi[1];
    end else if (ctrl.step) begin
      if (rowEnd) begin
        posX <= startX;
        posY <= posY + CW'(1);
      end else begin
        posX <= posX + CW'(1);
      end
    end
  end

  assign curMaskOn = pixMask[posX[MW-1:0]];

  // R5 (clip registers are not rewritten during a fill)
  pix_in_clip_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (posX >= clipMin[0] && posX <= clipMax[0] &&
                  posY >= clipMin[1] && posY <= clipMax[1]));

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> pixMask[posX[MW-1:0]]);

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !ctrl.take) |=> (pendValid && $stable(pendLo[0]) &&
      $stable(pendLo[1]) && $stable(pendHi[0]) && $stable(pendHi[1])));
endmodule

// File: rtl/fill_control.sv
module fill_control
  import fill_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  pendValid,
  input  logic  jobEmpty,
  input  logic  lastPix,
  input  logic  curMaskOn,
  input  logic  pixReady,
  output ctrl_t ctrl,
  output logic  pixValid,
  output logic  busy
);
  state_t state, stateNext;

  always_comb begin
    ctrl      = '0;
    pixValid  = 1'b0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (pendValid) begin
          ctrl.take = 1'b1;
          if (!jobEmpty) stateNext = S_RUN;
        end
      end
      S_RUN: begin
        pixValid  = curMaskOn;
        ctrl.step = !curMaskOn || pixReady;
        if (ctrl.step && lastPix) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == S_RUN) || pendValid;

  // R8
  pend_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && pendValid) |=> !pendValid);

  // R4
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && pendValid && jobEmpty) |=> (state == S_IDLE && !pixValid));
endmodule

// File: rtl/rect_fill.sv
module rect_fill
  import fill_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DW-1:0]     rdData,
  output logic              pixValid,
  input  logic              pixReady,
  output logic [CW-1:0]     pixX,
  output logic [CW-1:0]     pixY,
  output logic [DW-1:0]     pixColor,
  output logic [DW-1:0]     pixPlanes
);
  ctrl_t ctrl;
  logic  pendValid, jobEmpty, lastPix, curMaskOn, busy;

  fill_datapath #(.CW(CW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctrl(ctrl), .pixValid(pixValid), .pendValid(pendValid),
    .jobEmpty(jobEmpty), .lastPix(lastPix), .curMaskOn(curMaskOn),
    .posX(pixX), .posY(pixY), .fgColor(pixColor), .planeMask(pixPlanes)
  );

  fill_control u_ctl (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .jobEmpty(jobEmpty),
    .lastPix(lastPix), .curMaskOn(curMaskOn), .pixReady(pixReady),
    .ctrl(ctrl), .pixValid(pixValid), .busy(busy)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == A_STATUS) rdData[BUSY_BIT] = busy;
    if (rdAddr == A_DRAW) begin
      rdData[SIGN_BIT]     = pendValid;
      rdData[NOTREADY_BIT] = pendValid;
    end
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixX) && $stable(pixY)));
endmodule

// File: tb/tb_rect_fill.sv
module tb_rect_fill;
  import fill_pkg::*;
  localparam int CW = 12;
  localparam int DW = 32;
  localparam int MAXP = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [31:0] rdData;
  logic pixValid;
  logic pixReady = 1'b1;
  logic [CW-1:0] pixX, pixY;
  logic [31:0] pixColor, pixPlanes;

  rect_fill #(.CW(CW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pixValid(pixValid), .pixReady(pixReady),
    .pixX(pixX), .pixY(pixY), .pixColor(pixColor), .pixPlanes(pixPlanes)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails = 0;
  int readyMode = 0;  // 0 always ready, 1 pseudo-random, 2 held low
  logic [7:0] lfsr = 8'h5A;

  // bench copy of programmed state
  int mClipX0 = 0, mClipY0 = 0, mClipX1 = 4095, mClipY1 = 4095;
  logic [31:0] mMask = 32'hFFFF_FFFF;
  logic [31:0] mColor = 0, mPlanes = 32'hFFFF_FFFF;

  int recN = 0, expN = 0;
  int recX [MAXP], recY [MAXP], expX [MAXP], expY [MAXP];
  logic [31:0] recC [MAXP], recP [MAXP];
  int stallErr = 0;
  logic prevStall = 1'b0;
  logic [CW-1:0] prevX, prevY;

  // ready driver
  initial begin
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (readyMode == 0) pixReady = 1'b1;
      else if (readyMode == 1) pixReady = lfsr[0] & lfsr[2];
      else pixReady = 1'b0;
    end
  end

  // pixel monitor, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (prevStall && !(pixValid && pixX == prevX && pixY == prevY)) stallErr++;
      prevStall = pixValid && !pixReady;
      prevX = pixX;
      prevY = pixY;
      if (pixValid && pixReady && recN < MAXP) begin
        recX[recN] = int'(pixX);
        recY[recN] = int'(pixY);
        recC[recN] = pixColor;
        recP[recN] = pixPlanes;
        recN++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic put_rect(input int x0, input int y0, input int x1, input int y1);
    wr(A_RECT_Y, y0); wr(A_RECT_X, x0); wr(A_RECT_Y, y1); wr(A_RECT_X, x1);
  endtask

  task automatic expect_rect(input int x0, input int y0, input int x1, input int y1);
    for (int y = y0; y < y1; y++)
      for (int x = x0; x < x1; x++)
        if (x >= mClipX0 && x <= mClipX1 && y >= mClipY0 && y <= mClipY1 &&
            mMask[x % 32] && expN < MAXP) begin
          expX[expN] = x; expY[expN] = y; expN++;
        end
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin
      @(negedge clk); #1;
      rd(A_STATUS, s);
      n++;
    end while (s[BUSY_BIT] && n < 5000);
    check(!s[BUSY_BIT], tag, "busy clears", s, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    int bad = 0;
    check(recN == expN, tag, "pixel count", recN, expN);
    for (int i = 0; i < recN && i < expN; i++)
      if (recX[i] != expX[i] || recY[i] != expY[i] ||
          recC[i] != mColor || recP[i] != mPlanes) begin
        if (bad == 0)
          $display("FAIL %s pixel %0d: actual (%0d,%0d,%0h,%0h) expected (%0d,%0d,%0h,%0h)",
                   tag, i, recX[i], recY[i], recC[i], recP[i],
                   expX[i], expY[i], mColor, mPlanes);
        bad++;
      end
    checks++;
    if (bad != 0) fails++;
    recN = 0; expN = 0;
  endtask

  task automatic t_reset;
    logic [31:0] s;
    rd(A_STATUS, s);
    check(s == 0, "R1", "engine status", s, 0);
    rd(A_DRAW, s);
    check(s == 0, "R1", "draw status", s, 0);
    check(pixValid == 1'b0, "R1", "pixValid", pixValid, 0);
  endtask

  task automatic t_basic;
    logic [31:0] s;
    mColor = 32'h00C0_FFEE; mPlanes = 32'h0000_FFFF;
    wr(A_COLOR, mColor); wr(A_PLANES, mPlanes);
    put_rect(2, 1, 6, 4);
    rd(A_STATUS, s);
    check(s[BUSY_BIT], "R2", "busy after second corner", s, 32'h1000_0000);
    expect_rect(2, 1, 6, 4);
    wait_idle("R2");
    compare("R3_R6_basic");
  endtask

  task automatic t_stall;
    readyMode = 1; stallErr = 0;
    put_rect(10, 20, 15, 23);
    expect_rect(10, 20, 15, 23);
    wait_idle("R3");
    compare("R3_stall");
    check(stallErr == 0, "R3", "pixel held while stalled", stallErr, 0);
    readyMode = 0;
  endtask

  task automatic t_empty;
    put_rect(5, 5, 5, 9);
    wait_idle("R4");
    check(recN == 0, "R4", "zero width draws nothing", recN, 0);
    put_rect(8, 8, 3, 9);
    wait_idle("R4");
    check(recN == 0, "R4", "negative width draws nothing", recN, 0);
    put_rect(1, 7, 4, 2);
    wait_idle("R4");
    check(recN == 0, "R4", "negative height draws nothing", recN, 0);
    recN = 0;
  endtask

  task automatic t_clip;
    mClipX0 = 3; mClipY0 = 2; mClipX1 = 5; mClipY1 = 3;
    wr(4, 3); wr(5, 2); wr(6, 5); wr(7, 3);
    put_rect(0, 0, 10, 10);
    expect_rect(0, 0, 10, 10);
    wait_idle("R5");
    check(expN == 6, "R5", "model size", expN, 6);
    compare("R5_clip");
    mClipX0 = 0; mClipY0 = 0; mClipX1 = 4095; mClipY1 = 4095;
    wr(4, 0); wr(5, 0); wr(6, 4095); wr(7, 4095);
  endtask

  task automatic t_mask;
    mMask = 32'hAAAA_AAAA;
    wr(A_PIXMASK, mMask);
    put_rect(28, 0, 36, 2);
    expect_rect(28, 0, 36, 2);
    wait_idle("R7");
    check(expN == 8, "R7", "model size", expN, 8);
    compare("R7_mask");
    mMask = 32'hFFFF_FFFF;
    wr(A_PIXMASK, mMask);
  endtask

  task automatic t_queue;
    logic [31:0] s;
    readyMode = 2;
    put_rect(0, 0, 4, 2);
    repeat (3) @(posedge clk);
    put_rect(100, 50, 103, 51);
    rd(A_DRAW, s);
    check(s == 32'hA000_0000, "R8", "draw status while held", s, 32'hA000_0000);
    put_rect(200, 200, 210, 210);
    rd(A_DRAW, s);
    check(s == 32'hA000_0000, "R9", "draw status after ignored writes", s, 32'hA000_0000);
    readyMode = 0;
    expect_rect(0, 0, 4, 2);
    expect_rect(100, 50, 103, 51);
    wait_idle("R8");
    compare("R8_R9_queue");
    rd(A_DRAW, s);
    check(s == 0, "R8", "draw status after drain", s, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_empty();
    t_clip();
    t_mask();
    t_queue();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule